// File: doc/BRIEF.md
# Transmit Frame DMA Reader

This block moves one outgoing frame at a time from system memory to a byte-wide frame sink. It keeps reading a two-word transmit descriptor at a fixed memory location. When the descriptor shows it is ready, the block takes the buffer pointer and byte length from it. It then fetches the buffer one 32-bit word at a time as a classic bus master and hands the bytes on through a valid/ready handshake. The final byte of the frame carries a last flag.

The link it feeds is treated as free of errors. The block waits on the sink for as long as the sink needs, and it never pads, adds a checksum or retries. After the sink has taken the whole frame, the block writes the first descriptor word back. That word clears the ready flag and reports clean status: zero retries and every error flag clear. The block then pulses an interrupt if the descriptor asked for one.

There are two faults, and both stop the block until reset. One is a buffer pointer that is not word aligned. The other is an error response from the bus.

Top module: `txdma_reader`

## Requirements
- R1: The block reads descriptor word 0 at `desc_addr_i` again and again. While its ready bit (bit 15) is 0, no byte is emitted and no write is made. Once the bit is 1, the frame is sent exactly once.
- R2: Word 0 bits 31:16 hold the frame length in bytes. Word 1, at `desc_addr_i`+4, holds the buffer pointer. Exactly that many bytes are emitted, in rising address order, with bits 7:0 of each word first. When the length is not a multiple of four, only the needed bytes of the final word are emitted. `tx_last_o` is high only with the final byte.
- R3: While `tx_valid_o` is high and `tx_ready_i` is low, the block holds `tx_valid_o`, `tx_data_o` and `tx_last_o` steady, with no time limit.
- R4: Word 0 bit 12 (pad enable) has no effect. A short frame is emitted at its own length, and no checksum bytes are appended.
- R5: After the final byte is accepted, word 0 is written back. Bits 31:16 and 14:9 are kept. Bit 15 is cleared. Bits 8:0 are written as 0: underrun is bit 8, retry count is bits 7:4, retry-limit error is bit 3, and bits 2:0 are defer, late and carrier-lost.
- R6: If word 0 bit 14 is set, `irq_o` pulses high for one cycle after the write-back completes. If bit 14 is clear, `irq_o` stays low.
- R7: A pointer with bits 1:0 not equal to 0 sets `align_fault_o`, which then stays high. No buffer read, no byte and no write-back follow.
- R8: Every bus address has bits 1:0 equal to 0, and `m_sel_o` is always 4'hF.
- R9: `m_stb_o` equals `m_cyc_o`. A request holds its address, write enable and write data steady until it receives ack or err.
- R10: With `IDLE_GAP`=1, `m_cyc_o` is low in the cycle after each ack or err.
- R11: An err response aborts the frame. `bus_fault_o` is then set and stays high. There is no further byte, no write-back and no interrupt.
- R12: A length of 0 leads straight to the write-back, with no bytes emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_addr_i | input | ADDR_W | Byte address of descriptor word 0 |
| m_adr_o | output | ADDR_W | Bus byte address |
| m_dat_o | output | 32 | Bus write data |
| m_dat_i | input | 32 | Bus read data |
| m_sel_o | output | 4 | Bus byte selects |
| m_we_o | output | 1 | Bus write enable |
| m_cyc_o | output | 1 | Bus cycle |
| m_stb_o | output | 1 | Bus strobe |
| m_ack_i | input | 1 | Bus acknowledge |
| m_err_i | input | 1 | Bus error response |
| tx_data_o | output | 8 | Frame byte |
| tx_valid_o | output | 1 | Frame byte valid |
| tx_last_o | output | 1 | Final byte of frame |
| tx_ready_i | input | 1 | Sink accepts byte |
| irq_o | output | 1 | Frame-sent interrupt pulse |
| align_fault_o | output | 1 | Misaligned buffer pointer seen |
| bus_fault_o | output | 1 | Bus error seen |

## Verification
The bench sends frames of 10, 8, 1 and 0 bytes:
- A 10-byte frame exercises the partial final word. A design that read the whole word would emit two extra bytes. One that tagged the word boundary would raise the last flag in the wrong place.
- An 8-byte frame under a stalling sink, including a stall of roughly 60 cycles, catches any byte that changes or is dropped while the sink is not ready.

It then checks each fault case:
- A descriptor that is not ready is left alone for many cycles and then released, which catches early or repeated sends.
- A misaligned pointer must produce no buffer read at all.
- An error on the second buffer word must leave exactly four bytes out and the descriptor untouched.
- The exact written-back word exposes any error or pad bit that leaks into the status.

// File: rtl/txdma_pkg.sv
package txdma_pkg;
   localparam int DATA_W     = 32;
   localparam int LEN_W      = 16;
   localparam int LEN_LSB    = 16;
   localparam int BIT_READY  = 15;
   localparam int BIT_IRQ    = 14;
   localparam int KEEP_LSB   = 9;
   localparam int KEEP_W     = BIT_READY - KEEP_LSB;
   localparam int STATUS_W   = KEEP_LSB;

   typedef enum logic [2:0] {
      ST_POLL,
      ST_PTR,
      ST_FETCH,
      ST_DRAIN,
      ST_WBACK,
      ST_HALT
   } ctrl_st_t;
endpackage

// File: rtl/txdma_busport.sv
module txdma_busport
   import txdma_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int IDLE_GAP = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              req_we_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [DATA_W-1:0] req_wdata_i,
   output logic              done_o,
   output logic              fail_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic [ADDR_W-1:0] m_adr_o,
   output logic [DATA_W-1:0] m_dat_o,
   input  logic [DATA_W-1:0] m_dat_i,
   output logic [3:0]        m_sel_o,
   output logic              m_we_o,
   output logic              m_cyc_o,
   output logic              m_stb_o,
   input  logic              m_ack_i,
   input  logic              m_err_i
);
   logic hold;

   generate
      if (IDLE_GAP != 0) begin : g_gap
         logic gap_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) gap_q <= 1'b0;
            else        gap_q <= m_cyc_o && (m_ack_i || m_err_i);
         end
         assign hold = gap_q;

         // R10: one idle cycle after every completed access
         a_r10_idle_gap: assert property (@(posedge clk) disable iff (!rst_n)
            (m_cyc_o && (m_ack_i || m_err_i)) |=> !m_cyc_o);
      end else begin : g_nogap
         assign hold = 1'b0;
      end
   endgenerate

   assign m_cyc_o = req_i && !hold;
   assign m_stb_o = m_cyc_o;
   assign m_we_o  = req_we_i && m_cyc_o;
   assign m_adr_o = req_addr_i;
   assign m_dat_o = req_wdata_i;
   assign m_sel_o = 4'hF;
   assign done_o  = m_cyc_o && m_ack_i;
   assign fail_o  = m_cyc_o && m_err_i;
   assign rdata_o = m_dat_i;

   // R9: request held until answered
   a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
      (m_cyc_o && !m_ack_i && !m_err_i) |=>
         (m_cyc_o && $stable(m_adr_o) && $stable(m_we_o) && $stable(m_dat_o)));
   // R8: word aligned addresses only
   a_r8_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      m_cyc_o |-> (m_adr_o[1:0] == 2'b00));
endmodule

// File: rtl/txdma_unpack.sv
module txdma_unpack
   import txdma_pkg::*;
#(
   parameter int MSB_FIRST = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [DATA_W-1:0] word_i,
   input  logic [2:0]        nbytes_i,
   input  logic              final_i,
   output logic              empty_o,
   output logic [7:0]        tx_data_o,
   output logic              tx_valid_o,
   output logic              tx_last_o,
   input  logic              tx_ready_i
);
   localparam int LANES = DATA_W / 8;
   localparam int IDX_W = $clog2(LANES);

   logic [DATA_W-1:0] word_q;
   logic [IDX_W-1:0]  idx_q;
   logic [2:0]        cnt_q;
   logic              final_q;
   logic [IDX_W-1:0]  lane;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q  <= '0;
         idx_q   <= '0;
         cnt_q   <= '0;
         final_q <= 1'b0;
      end else if (load_i) begin
         word_q  <= word_i;
         idx_q   <= '0;
         cnt_q   <= nbytes_i;
         final_q <= final_i;
      end else if (tx_valid_o && tx_ready_i) begin
         idx_q <= idx_q + 1'b1;
         cnt_q <= cnt_q - 3'd1;
      end
   end

   generate
      if (MSB_FIRST != 0) begin : g_msb
         assign lane = IDX_W'(LANES - 1) - idx_q;
      end else begin : g_lsb
         assign lane = idx_q;
      end
   endgenerate

   assign empty_o    = (cnt_q == 3'd0);
   assign tx_valid_o = !empty_o;
   assign tx_data_o  = word_q[8*lane +: 8];
   assign tx_last_o  = tx_valid_o && final_q && (cnt_q == 3'd1);

   // R3: byte held steady under back-pressure
   a_r3_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid_o && !tx_ready_i && !load_i) |=>
         (tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o)));
   // R2: a new word never overwrites unsent bytes
   a_r2_load_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |-> empty_o);
endmodule

// File: rtl/txdma_ctrl.sv
module txdma_ctrl
   import txdma_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] desc_addr_i,
   output logic              req_o,
   output logic              req_we_o,
   output logic [ADDR_W-1:0] req_addr_o,
   output logic [DATA_W-1:0] req_wdata_o,
   input  logic              done_i,
   input  logic              fail_i,
   input  logic [DATA_W-1:0] rdata_i,
   output logic              load_o,
   output logic [DATA_W-1:0] word_o,
   output logic [2:0]        nbytes_o,
   output logic              final_o,
   input  logic              unpack_empty_i,
   output logic              irq_o,
   output logic              align_fault_o,
   output logic              bus_fault_o
);
   localparam logic [ADDR_W-1:0] WSTEP = ADDR_W'(DATA_W / 8);

   ctrl_st_t          st_q;
   logic [LEN_W-1:0]  len_q;
   logic [KEEP_W-1:0] keep_q;
   logic [LEN_W-1:0]  remain_q;
   logic [ADDR_W-1:0] ptr_q;
   logic              irq_q, align_q, berr_q;

   always_comb begin
      req_o      = (st_q == ST_POLL) || (st_q == ST_PTR) ||
                   (st_q == ST_FETCH) || (st_q == ST_WBACK);
      req_we_o   = (st_q == ST_WBACK);
      case (st_q)
         ST_PTR:   req_addr_o = desc_addr_i + WSTEP;
         ST_FETCH: req_addr_o = ptr_q;
         default:  req_addr_o = desc_addr_i;
      endcase
      req_wdata_o = {len_q, 1'b0, keep_q, {STATUS_W{1'b0}}};
   end

   assign nbytes_o = (remain_q >= LEN_W'(4)) ? 3'd4 : remain_q[2:0];
   assign final_o  = (remain_q <= LEN_W'(4));
   assign word_o   = rdata_i;
   assign load_o   = (st_q == ST_FETCH) && done_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_POLL;
         len_q    <= '0;
         keep_q   <= '0;
         remain_q <= '0;
         ptr_q    <= '0;
         irq_q    <= 1'b0;
         align_q  <= 1'b0;
         berr_q   <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         if (fail_i) begin
            st_q   <= ST_HALT;
            berr_q <= 1'b1;
         end else begin
            case (st_q)
               ST_POLL: if (done_i && rdata_i[BIT_READY]) begin
                  len_q    <= rdata_i[LEN_LSB +: LEN_W];
                  remain_q <= rdata_i[LEN_LSB +: LEN_W];
                  keep_q   <= rdata_i[KEEP_LSB +: KEEP_W];
                  st_q     <= ST_PTR;
               end
               ST_PTR: if (done_i) begin
                  ptr_q <= rdata_i[ADDR_W-1:0];
                  if (rdata_i[1:0] != 2'b00) begin
                     align_q <= 1'b1;
                     st_q    <= ST_HALT;
                  end else if (remain_q == '0) begin
                     st_q <= ST_WBACK;
                  end else begin
                     st_q <= ST_FETCH;
                  end
               end
               ST_FETCH: if (done_i) begin
                  remain_q <= remain_q - LEN_W'(nbytes_o);
                  ptr_q    <= ptr_q + WSTEP;
                  st_q     <= ST_DRAIN;
               end
               ST_DRAIN: if (unpack_empty_i) begin
                  st_q <= (remain_q == '0) ? ST_WBACK : ST_FETCH;
               end
               ST_WBACK: if (done_i) begin
                  irq_q <= keep_q[BIT_IRQ - KEEP_LSB];
                  st_q  <= ST_POLL;
               end
               default: st_q <= ST_HALT;
            endcase
         end
      end
   end

   assign irq_o         = irq_q;
   assign align_fault_o = align_q;
   assign bus_fault_o   = berr_q;

   // R7: alignment fault is sticky and silences the bus
   a_r7_align_halt: assert property (@(posedge clk) disable iff (!rst_n)
      align_fault_o |=> (align_fault_o && !req_o));
   // R11: bus fault is sticky and silences the bus
   a_r11_bus_halt: assert property (@(posedge clk) disable iff (!rst_n)
      bus_fault_o |=> (bus_fault_o && !req_o));
   // R6: interrupt lasts one cycle
   a_r6_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o);
endmodule

// File: rtl/txdma_reader.sv
module txdma_reader
   import txdma_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int IDLE_GAP  = 1,
   parameter int MSB_FIRST = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] desc_addr_i,
   output logic [ADDR_W-1:0] m_adr_o,
   output logic [31:0]       m_dat_o,
   input  logic [31:0]       m_dat_i,
   output logic [3:0]        m_sel_o,
   output logic              m_we_o,
   output logic              m_cyc_o,
   output logic              m_stb_o,
   input  logic              m_ack_i,
   input  logic              m_err_i,
   output logic [7:0]        tx_data_o,
   output logic              tx_valid_o,
   output logic              tx_last_o,
   input  logic              tx_ready_i,
   output logic              irq_o,
   output logic              align_fault_o,
   output logic              bus_fault_o
);
   initial begin
      assert (ADDR_W >= 8 && ADDR_W <= DATA_W)
         else $error("txdma_reader: ADDR_W must lie in 8..32");
      assert (IDLE_GAP == 0 || IDLE_GAP == 1)
         else $error("txdma_reader: IDLE_GAP must be 0 or 1");
      assert (MSB_FIRST == 0 || MSB_FIRST == 1)
         else $error("txdma_reader: MSB_FIRST must be 0 or 1");
   end

   logic              req, req_we, done, fail, load, fin, empty;
   logic [ADDR_W-1:0] req_addr;
   logic [DATA_W-1:0] req_wdata, rdata, word;
   logic [2:0]        nbytes;

   txdma_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .desc_addr_i(desc_addr_i),
      .req_o(req), .req_we_o(req_we), .req_addr_o(req_addr), .req_wdata_o(req_wdata),
      .done_i(done), .fail_i(fail), .rdata_i(rdata),
      .load_o(load), .word_o(word), .nbytes_o(nbytes), .final_o(fin),
      .unpack_empty_i(empty), .irq_o(irq_o),
      .align_fault_o(align_fault_o), .bus_fault_o(bus_fault_o)
   );

   txdma_busport #(.ADDR_W(ADDR_W), .IDLE_GAP(IDLE_GAP)) u_bus (
      .clk(clk), .rst_n(rst_n),
      .req_i(req), .req_we_i(req_we), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
      .done_o(done), .fail_o(fail), .rdata_o(rdata),
      .m_adr_o(m_adr_o), .m_dat_o(m_dat_o), .m_dat_i(m_dat_i), .m_sel_o(m_sel_o),
      .m_we_o(m_we_o), .m_cyc_o(m_cyc_o), .m_stb_o(m_stb_o),
      .m_ack_i(m_ack_i), .m_err_i(m_err_i)
   );

   txdma_unpack #(.MSB_FIRST(MSB_FIRST)) u_unpack (
      .clk(clk), .rst_n(rst_n),
      .load_i(load), .word_i(word), .nbytes_i(nbytes), .final_i(fin),
      .empty_o(empty), .tx_data_o(tx_data_o), .tx_valid_o(tx_valid_o),
      .tx_last_o(tx_last_o), .tx_ready_i(tx_ready_i)
   );

   // R5: write-back only once every byte has left
   a_r5_wb_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
      m_we_o |-> !tx_valid_o);
   // R6: interrupt follows a completed write-back
   a_r6_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> $past(m_cyc_o && m_we_o && m_ack_i));
endmodule

// File: tb/txdma_reader_tb.sv
module txdma_reader_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int BUF_WORD   = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] m_adr, m_dat_o, m_dat_i;
   logic [3:0]  m_sel;
   logic        m_we, m_cyc, m_stb;
   logic        m_ack = 1'b0, m_err = 1'b0;
   logic [7:0]  tx_data;
   logic        tx_valid, tx_last;
   logic        tx_ready = 1'b1;
   logic        irq, align_fault, bus_fault;

   logic [31:0] mem [0:63];
   int          err_idx = -1;
   int          ready_mode = 0;
   int          n_tests = 0, n_fail = 0;

   logic [7:0]  rx_buf  [0:63];
   logic        rx_lastf[0:63];
   int          rx_cnt, irq_cnt, gap_viol, bus_viol, stall_viol, buf_reads, desc_reads, since_rst;
   logic        p_done, p_valid, p_ready, p_last;
   logic [7:0]  p_data;

   always #(CLK_PERIOD/2) clk = ~clk;

   txdma_reader dut_i (
      .clk(clk), .rst_n(rst_n), .desc_addr_i(32'h0),
      .m_adr_o(m_adr), .m_dat_o(m_dat_o), .m_dat_i(m_dat_i), .m_sel_o(m_sel),
      .m_we_o(m_we), .m_cyc_o(m_cyc), .m_stb_o(m_stb),
      .m_ack_i(m_ack), .m_err_i(m_err),
      .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_last_o(tx_last), .tx_ready_i(tx_ready),
      .irq_o(irq), .align_fault_o(align_fault), .bus_fault_o(bus_fault)
   );

   // memory slave, registered response
   always @(posedge clk) begin
      if (!rst_n) begin
         m_ack <= 1'b0; m_err <= 1'b0;
      end else if (m_cyc && m_stb && !m_ack && !m_err) begin
         if (int'(m_adr[7:2]) == err_idx) m_err <= 1'b1;
         else begin
            m_ack <= 1'b1;
            if (m_we) mem[m_adr[7:2]] <= m_dat_o;
            else      m_dat_i <= mem[m_adr[7:2]];
         end
      end else begin
         m_ack <= 1'b0; m_err <= 1'b0;
      end
   end

   // monitors
   always @(posedge clk) begin
      if (!rst_n) begin
         rx_cnt <= 0; irq_cnt <= 0; gap_viol <= 0; bus_viol <= 0; stall_viol <= 0;
         buf_reads <= 0; desc_reads <= 0; since_rst <= 0;
         p_done <= 1'b0; p_valid <= 1'b0; p_ready <= 1'b0; p_last <= 1'b0; p_data <= 8'h0;
      end else begin
         since_rst <= since_rst + 1;
         if (tx_valid && tx_ready) begin
            rx_buf[rx_cnt]   <= tx_data;
            rx_lastf[rx_cnt] <= tx_last;
            rx_cnt <= rx_cnt + 1;
         end
         if (irq) irq_cnt <= irq_cnt + 1;
         if (p_done && m_cyc) gap_viol <= gap_viol + 1;
         if (m_cyc && (m_adr[1:0] != 2'b00 || m_sel != 4'hF || m_stb != m_cyc))
            bus_viol <= bus_viol + 1;
         if (p_valid && !p_ready && (!tx_valid || tx_data != p_data || tx_last != p_last))
            stall_viol <= stall_viol + 1;
         if (m_cyc && m_ack && !m_we && m_adr >= 32'h40) buf_reads <= buf_reads + 1;
         if (m_cyc && m_ack && !m_we && m_adr == 32'h0) desc_reads <= desc_reads + 1;
         p_done <= m_cyc && (m_ack || m_err);
         p_valid <= tx_valid; p_ready <= tx_ready; p_data <= tx_data; p_last <= tx_last;
      end
   end

   // sink readiness, driven away from the sampling edge
   always @(negedge clk) begin
      if (ready_mode == 0) tx_ready = 1'b1;
      else if (since_rst >= 14 && since_rst < 74) tx_ready = 1'b0;
      else tx_ready = since_rst[0] ^ since_rst[2];
   end

   function automatic logic [7:0] exp_byte(input int k);
      return 8'(8'h21 + k * 13);
   endfunction

   function automatic logic [31:0] desc_word(input int len, input logic rdy, input logic irqe);
      // pad bit 12 and bits 13,11,10,9 set; status bits 8:0 dirty
      return {16'(len), rdy, irqe, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 9'h1FF};
   endfunction

   function automatic logic [31:0] wb_word(input logic [31:0] w0);
      return {w0[31:16], 1'b0, w0[14:9], 9'h000};
   endfunction

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic setup(input logic [31:0] w0, input logic [31:0] ptr, input int mode, input int eidx);
      rst_n = 1'b0;
      for (int i = 0; i < 64; i++) mem[i] = 32'h0;
      for (int w = 0; w < 16; w++)
         mem[BUF_WORD + w] = {exp_byte(4*w+3), exp_byte(4*w+2), exp_byte(4*w+1), exp_byte(4*w)};
      mem[0] = w0; mem[1] = ptr;
      ready_mode = mode; err_idx = eidx;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wait_done();
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (!mem[0][15] || align_fault || bus_fault) break;
      end
      repeat (6) @(negedge clk);
   endtask

   task automatic chk_frame(input int len, input string req);
      chk(rx_cnt == len, req, rx_cnt, len);
      for (int k = 0; k < len; k++) begin
         chk(rx_buf[k] == exp_byte(k), req, rx_buf[k], exp_byte(k));
         chk(rx_lastf[k] == (k == len - 1), req, rx_lastf[k], (k == len - 1));
      end
   endtask

   task automatic t_reset();
      setup(32'h0, 32'h40, 0, -1);
      repeat (30) @(negedge clk);
      chk(tx_valid == 1'b0, "R1 idle valid", tx_valid, 0);
      chk(irq_cnt == 0 && !align_fault && !bus_fault, "R1 idle flags", irq_cnt, 0);
      chk(mem[0] == 32'h0, "R1 no write", mem[0], 0);
      chk(desc_reads >= 3, "R1 polling", desc_reads, 3);
   endtask

   task automatic t_poll_frame();
      logic [31:0] w0 = desc_word(10, 1'b0, 1'b1);
      setup(w0, 32'h40, 0, -1);
      repeat (40) @(negedge clk);
      chk(rx_cnt == 0, "R1 not ready", rx_cnt, 0);
      chk(mem[0] == w0, "R1 untouched", mem[0], w0);
      w0[15] = 1'b1;
      mem[0] = w0;
      wait_done();
      chk_frame(10, "R2/R4 len10");
      chk(mem[0] == wb_word(w0), "R5 writeback", mem[0], wb_word(w0));
      chk(irq_cnt == 1, "R6 irq", irq_cnt, 1);
      chk(gap_viol == 0, "R10 gap", gap_viol, 0);
      chk(bus_viol == 0, "R8/R9 bus", bus_viol, 0);
      repeat (30) @(negedge clk);
      chk(rx_cnt == 10, "R1 once", rx_cnt, 10);
   endtask

   task automatic t_stall();
      logic [31:0] w0 = desc_word(8, 1'b1, 1'b0);
      setup(w0, 32'h40, 1, -1);
      wait_done();
      chk_frame(8, "R3 stall");
      chk(stall_viol == 0, "R3 hold", stall_viol, 0);
      chk(irq_cnt == 0, "R6 no irq", irq_cnt, 0);
      chk(mem[0] == wb_word(w0), "R5 writeback8", mem[0], wb_word(w0));
   endtask

   task automatic t_len1();
      logic [31:0] w0 = desc_word(1, 1'b1, 1'b1);
      setup(w0, 32'h40, 0, -1);
      wait_done();
      chk_frame(1, "R2 len1");
      chk(mem[0] == wb_word(w0), "R5 writeback1", mem[0], wb_word(w0));
      chk(irq_cnt == 1, "R6 irq1", irq_cnt, 1);
   endtask

   task automatic t_zero();
      logic [31:0] w0 = desc_word(0, 1'b1, 1'b1);
      setup(w0, 32'h40, 0, -1);
      wait_done();
      chk(rx_cnt == 0, "R12 no bytes", rx_cnt, 0);
      chk(buf_reads == 0, "R12 no fetch", buf_reads, 0);
      chk(mem[0] == wb_word(w0), "R12 writeback", mem[0], wb_word(w0));
      chk(irq_cnt == 1, "R12 irq", irq_cnt, 1);
   endtask

   task automatic t_align();
      logic [31:0] w0 = desc_word(6, 1'b1, 1'b1);
      setup(w0, 32'h42, 0, -1);
      repeat (60) @(negedge clk);
      chk(align_fault == 1'b1, "R7 fault", align_fault, 1);
      chk(rx_cnt == 0, "R7 no bytes", rx_cnt, 0);
      chk(buf_reads == 0, "R7 no fetch", buf_reads, 0);
      chk(mem[0] == w0, "R7 no writeback", mem[0], w0);
      chk(irq_cnt == 0, "R7 no irq", irq_cnt, 0);
   endtask

   task automatic t_buserr();
      logic [31:0] w0 = desc_word(12, 1'b1, 1'b1);
      setup(w0, 32'h40, 0, BUF_WORD + 1);
      repeat (80) @(negedge clk);
      chk(bus_fault == 1'b1, "R11 fault", bus_fault, 1);
      chk(rx_cnt == 4, "R11 abort", rx_cnt, 4);
      chk(mem[0] == w0, "R11 no writeback", mem[0], w0);
      chk(irq_cnt == 0, "R11 no irq", irq_cnt, 0);
      chk(gap_viol == 0, "R10 gap err", gap_viol, 0);
   endtask

   initial begin
      t_reset();
      t_poll_frame();
      t_stall();
      t_len1();
      t_zero();
      t_align();
      t_buserr();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule